// File: doc/BRIEF.md
# Queue Interrupt Condition Controller

This block turns per-queue status flags into two interrupt request lines for a set of 64 hardware queues split into a lower and an upper half of 32. Every lower-half queue carries four flags (empty, nearly empty, nearly full, full) and a programmable 3-bit source code. The code picks one flag and can invert it to form the queue's interrupt condition. Every upper-half queue always uses its not-nearly-empty flag. A separate full flag is kept for the upper half, but it can only be read.

Each half has an enable word and a sticky status word. A status bit latches while its condition holds and its queue is enabled. Software clears it by writing a one, or by disabling the queue. Each half drives a registered interrupt line that is high while any enabled status bit is set. A word-addressed register port is used to program the source codes and enables, to clear status, and to read back the sampled flags.

Top module: `qic_ctrl`

## Requirements
- R1: While reset is held, every lower-queue flag nibble reads 0x3, the upper not-nearly-empty word reads 0xFFFFFFFF, the upper full word reads 0, and the source, enable and status words read 0. Both interrupt lines are low.
- R2: Lower queue q keeps its source code in source word q/8 (addresses 0 to 3), at bits [4*(q%8)+2 : 4*(q%8)]. Bit 4*(q%8)+3 is reserved: writes to it are dropped and it reads 0.
- R3: Code bits [1:0] pick one bit of the queue's flag nibble lo_flags_i[4q+3:4q]: 0 picks empty (bit 0), 1 nearly empty (bit 1), 2 nearly full (bit 2) and 3 full (bit 3).
- R4: Code bit 2 inverts the picked flag, so code 4 raises the condition when the queue is not empty.
- R5: Upper queue 32+k raises its condition only from hi_nne_i[k]. Its full flag and the source words have no effect on it.
- R6: A status bit (lower at address 6, upper at 7) becomes set on the cycle after the sampled condition and the enable bit are both true. It stays set after the condition drops.
- R7: Writing a status address clears the bits that are one in the write data and leaves the zero bits as they are. When a set and a clear fall in the same cycle, the bit stays set.
- R8: Writing a zero to a set enable bit (lower at address 4, upper at 5) clears that queue's status bit in the same cycle. A queue that is not enabled never has a status bit set.
- R9: Each interrupt line is a register. It equals the OR of its half's status bits masked by that half's enables, and it updates on the same edge as the status word.
- R10: The flag inputs are registered every cycle. The lower flags read at addresses 8 to 11 (eight nibbles per word), the upper not-nearly-empty flags at 12, and the upper full flags at 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 4 | Register word address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| lo_flags_i | input | 128 | Lower-half flag nibbles, queue q at [4q+3:4q] |
| hi_nne_i | input | 32 | Upper-half not-nearly-empty flags |
| hi_full_i | input | 32 | Upper-half full flags |
| irq_lo_o | output | 1 | Lower-half interrupt request |
| irq_hi_o | output | 1 | Upper-half interrupt request |

## Verification
A wrong decode of a source code, such as a swapped flag index or a lost inversion, shows up two edges after a flag input changes. The status word then holds the wrong bit and the interrupt line follows on that same edge. A status word that fails to clear, or that keeps a bit for a disabled queue, is visible on the very next read and on the interrupt line. A flag register with the wrong reset value is seen by reading during reset. The bench moves one flag of one enabled queue at a time, so a decode fault cannot be hidden by another queue.

// File: rtl/qic_pkg.sv
package qic_pkg;
  localparam int FLAG_W = 4;
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    FLG_EMPTY  = 2'd0,
    FLG_NEMPTY = 2'd1,
    FLG_NFULL  = 2'd2,
    FLG_FULL   = 2'd3
  } flag_sel_e;

  localparam logic [FLAG_W-1:0] FLAG_RST_NIBBLE = 4'h3;
endpackage

// File: rtl/qic_rst_sync.sv
module qic_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= 2'b00;
    else         chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_sync_no = chain_q[1];
endmodule

// File: rtl/qic_cond_decode.sv
module qic_cond_decode
  import qic_pkg::*;
#(
  parameter int NQ = 32
) (
  input  logic [FLAG_W*NQ-1:0] flags_i,
  input  logic [CODE_W*NQ-1:0] codes_i,
  output logic [NQ-1:0]        cond_o
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [FLAG_W-1:0] nib;
    logic [CODE_W-1:0] code;
    flag_sel_e         pick;
    logic              raw;

    assign nib  = flags_i[FLAG_W*q +: FLAG_W];
    assign code = codes_i[CODE_W*q +: CODE_W];
    assign pick = flag_sel_e'(code[1:0]);

    always_comb begin
      unique case (pick)
        FLG_EMPTY:  raw = nib[0];
        FLG_NEMPTY: raw = nib[1];
        FLG_NFULL:  raw = nib[2];
        default:    raw = nib[3];
      endcase
    end

    // code bit 2 inverts the picked flag
    assign cond_o[q] = raw ^ code[2];
  end
endmodule

// File: rtl/qic_irq_half.sv
module qic_irq_half #(
  parameter int NQ = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NQ-1:0] cond_i,
  input  logic          en_we_i,
  input  logic          st_we_i,
  input  logic [NQ-1:0] wdata_i,
  output logic [NQ-1:0] en_o,
  output logic [NQ-1:0] st_o,
  output logic          irq_o
);
  logic [NQ-1:0] en_q, en_d;
  logic [NQ-1:0] st_q, st_d;
  logic [NQ-1:0] clr_mask, set_mask;
  logic          irq_q, irq_d;

  always_comb begin
    en_d     = en_we_i ? wdata_i : en_q;
    clr_mask = st_we_i ? wdata_i : '0;
    set_mask = cond_i & en_q;
    // set beats clear; a dropped enable removes the pending bit
    st_d     = ((st_q & ~clr_mask) | set_mask) & en_d;
    irq_d    = |(st_d & en_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      st_q  <= st_d;
      irq_q <= irq_d;
    end
  end

  assign en_o  = en_q;
  assign st_o  = st_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/qic_ctrl.sv
module qic_ctrl
  import qic_pkg::*;
#(
  parameter int HALF_Q = 32,
  parameter int ADDR_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic                 reg_wr_i,
  input  logic [HALF_Q-1:0]    reg_wdata_i,
  output logic [HALF_Q-1:0]    reg_rdata_o,
  input  logic [4*HALF_Q-1:0]  lo_flags_i,
  input  logic [HALF_Q-1:0]    hi_nne_i,
  input  logic [HALF_Q-1:0]    hi_full_i,
  output logic                 irq_lo_o,
  output logic                 irq_hi_o
);
  localparam int DATA_W    = HALF_Q;
  localparam int SLOTS     = DATA_W / FLAG_W;
  localparam int SRC_WORDS = HALF_Q / SLOTS;
  localparam int FLG_WORDS = (FLAG_W * HALF_Q) / DATA_W;
  localparam int A_SRC     = 0;
  localparam int A_EN_LO   = A_SRC + SRC_WORDS;
  localparam int A_EN_HI   = A_EN_LO + 1;
  localparam int A_ST_LO   = A_EN_HI + 1;
  localparam int A_ST_HI   = A_ST_LO + 1;
  localparam int A_FLG     = A_ST_HI + 1;
  localparam int A_NNE     = A_FLG + FLG_WORDS;
  localparam int A_FULL    = A_NNE + 1;

  logic rst_sync_n;

  qic_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  // source codes
  logic [CODE_W*HALF_Q-1:0] src_q, src_d;

  always_comb begin
    src_d = src_q;
    for (int w = 0; w < SRC_WORDS; w++) begin
      if (reg_wr_i && reg_addr_i == ADDR_W'(A_SRC + w)) begin
        for (int j = 0; j < SLOTS; j++) begin
          src_d[CODE_W*(w*SLOTS+j) +: CODE_W] = reg_wdata_i[FLAG_W*j +: CODE_W];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) src_q <= '0;
    else             src_q <= src_d;
  end

  // sampled flags
  logic [4*HALF_Q-1:0] lo_flag_q;
  logic [HALF_Q-1:0]   nne_q, full_q;

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lo_flag_q <= {HALF_Q{FLAG_RST_NIBBLE}};
      nne_q     <= '1;
      full_q    <= '0;
    end else begin
      lo_flag_q <= lo_flags_i;
      nne_q     <= hi_nne_i;
      full_q    <= hi_full_i;
    end
  end

  // condition decode
  logic [HALF_Q-1:0] cond_lo;

  qic_cond_decode #(.NQ(HALF_Q)) u_dec (
    .flags_i (lo_flag_q),
    .codes_i (src_q),
    .cond_o  (cond_lo)
  );

  // per-half enable / status / request
  logic [HALF_Q-1:0] en_lo, st_lo, en_hi, st_hi;
  logic wr_en_lo, wr_en_hi, wr_st_lo, wr_st_hi;

  assign wr_en_lo = reg_wr_i && reg_addr_i == ADDR_W'(A_EN_LO);
  assign wr_en_hi = reg_wr_i && reg_addr_i == ADDR_W'(A_EN_HI);
  assign wr_st_lo = reg_wr_i && reg_addr_i == ADDR_W'(A_ST_LO);
  assign wr_st_hi = reg_wr_i && reg_addr_i == ADDR_W'(A_ST_HI);

  qic_irq_half #(.NQ(HALF_Q)) u_lo (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .cond_i  (cond_lo),
    .en_we_i (wr_en_lo),
    .st_we_i (wr_st_lo),
    .wdata_i (reg_wdata_i),
    .en_o    (en_lo),
    .st_o    (st_lo),
    .irq_o   (irq_lo_o)
  );

  qic_irq_half #(.NQ(HALF_Q)) u_hi (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .cond_i  (nne_q),
    .en_we_i (wr_en_hi),
    .st_we_i (wr_st_hi),
    .wdata_i (reg_wdata_i),
    .en_o    (en_hi),
    .st_o    (st_hi),
    .irq_o   (irq_hi_o)
  );

  // read path
  always_comb begin
    reg_rdata_o = '0;
    for (int w = 0; w < SRC_WORDS; w++) begin
      if (reg_addr_i == ADDR_W'(A_SRC + w)) begin
        for (int j = 0; j < SLOTS; j++) begin
          reg_rdata_o[FLAG_W*j +: CODE_W] = src_q[CODE_W*(w*SLOTS+j) +: CODE_W];
        end
      end
    end
    for (int w = 0; w < FLG_WORDS; w++) begin
      if (reg_addr_i == ADDR_W'(A_FLG + w)) reg_rdata_o = lo_flag_q[DATA_W*w +: DATA_W];
    end
    if (reg_addr_i == ADDR_W'(A_EN_LO)) reg_rdata_o = en_lo;
    if (reg_addr_i == ADDR_W'(A_EN_HI)) reg_rdata_o = en_hi;
    if (reg_addr_i == ADDR_W'(A_ST_LO)) reg_rdata_o = st_lo;
    if (reg_addr_i == ADDR_W'(A_ST_HI)) reg_rdata_o = st_hi;
    if (reg_addr_i == ADDR_W'(A_NNE))   reg_rdata_o = nne_q;
    if (reg_addr_i == ADDR_W'(A_FULL))  reg_rdata_o = full_q;
  end
endmodule

// File: rtl/qic_ctrl_sva.sv
module qic_ctrl_sva #(
  parameter int HALF_Q = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [HALF_Q-1:0] cond_lo,
  input logic [HALF_Q-1:0] en_lo,
  input logic [HALF_Q-1:0] st_lo,
  input logic [HALF_Q-1:0] en_hi,
  input logic [HALF_Q-1:0] st_hi,
  input logic [HALF_Q-1:0] nne_q,
  input logic              irq_lo,
  input logic              irq_hi
);
  // R6: an enabled true condition is latched on the next edge
  p_set_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_lo & en_lo & $past(cond_lo & en_lo)) == (en_lo & $past(cond_lo & en_lo)));

  // R8: no pending bit survives without its enable
  p_dis_clear_lo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_lo & ~en_lo) == '0);
  p_dis_clear_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_hi & ~en_hi) == '0);

  // R5: upper bits only rise from the not-nearly-empty flag
  p_hi_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_hi & ~$past(st_hi) & ~$past(nne_q)) == '0);

  // R9: request lines track masked status
  p_irq_lo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_lo == |(st_lo & en_lo));
  p_irq_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hi == |(st_hi & en_hi));
endmodule

bind qic_ctrl qic_ctrl_sva #(.HALF_Q(HALF_Q)) u_sva (
  .clk_i   (clk_i),
  .rst_ni  (rst_sync_n),
  .cond_lo (cond_lo),
  .en_lo   (en_lo),
  .st_lo   (st_lo),
  .en_hi   (en_hi),
  .st_hi   (st_hi),
  .nne_q   (nne_q),
  .irq_lo  (irq_lo_o),
  .irq_hi  (irq_hi_o)
);

// File: tb/qic_ctrl_test.sv
`timescale 1ns/1ps
module qic_ctrl_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   addr;
  logic         wr;
  logic [31:0]  wdata;
  logic [31:0]  rdata;
  logic [127:0] lo_flags;
  logic [31:0]  nne, full;
  logic         irq_lo, irq_hi;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  qic_ctrl uut (
    .clk_i (clk), .rst_ni (rst_n), .reg_addr_i (addr), .reg_wr_i (wr),
    .reg_wdata_i (wdata), .reg_rdata_o (rdata), .lo_flags_i (lo_flags),
    .hi_nne_i (nne), .hi_full_i (full), .irq_lo_o (irq_lo), .irq_hi_o (irq_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wrr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(4'(a), d); chk("R1 ctrl word", d, 32'h0);
    end
    for (int a = 8; a < 12; a++) begin
      rd(4'(a), d); chk("R1 flag word", d, 32'h33333333);
    end
    rd(4'd12, d); chk("R1 nne word", d, 32'hFFFFFFFF);
    rd(4'd13, d); chk("R1 full word", d, 32'h0);
    chk("R1 irq", {30'b0, irq_hi, irq_lo}, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wrr(4'd0, 32'hFFFFFFFF);
    rd(4'd0, d); chk("R2 reserved bits", d, 32'h77777777);
    wrr(4'd0, 32'h0);
    wrr(4'd1, 32'h00007000);
    rd(4'd1, d); chk("R2 queue 11 slot", d, 32'h00007000);
    wrr(4'd1, 32'h0);
  endtask

  task automatic t_select_r3();
    logic [31:0] d;
    wrr(4'd0, 32'h00200000);         // queue 5 code 2: nearly full
    wrr(4'd4, 32'h00000020);
    @(negedge clk); lo_flags[23:20] = 4'b0010; settle();
    rd(4'd6, d); chk("R3 wrong flag ignored", d, 32'h0);
    chk("R3 irq quiet", {31'b0, irq_lo}, 32'h0);
    lo_flags[23:20] = 4'b0100; settle();
    rd(4'd6, d); chk("R3 nearly full selected", d, 32'h20);
    chk("R9 irq_lo high", {31'b0, irq_lo}, 32'h1);
    chk("R9 irq_hi low", {31'b0, irq_hi}, 32'h0);
    wrr(4'd4, 32'h0);
    rd(4'd6, d); chk("R8 disable clears", d, 32'h0);
    chk("R8 irq drops", {31'b0, irq_lo}, 32'h0);
    lo_flags = '0;
    wrr(4'd0, 32'h0);
  endtask

  task automatic t_invert_r4();
    logic [31:0] d;
    wrr(4'd1, 32'h00000040);         // queue 9 code 4: not empty
    @(negedge clk); lo_flags[39:36] = 4'b0001;
    wrr(4'd4, 32'h00000200);
    settle();
    rd(4'd6, d); chk("R4 empty gives no event", d, 32'h0);
    lo_flags[39:36] = 4'b0000; settle();
    rd(4'd6, d); chk("R4 not empty raises", d, 32'h200);
    lo_flags[39:36] = 4'b0001; settle();
    rd(4'd6, d); chk("R6 sticky after drop", d, 32'h200);
    wrr(4'd6, 32'hFFFFFDFF);
    rd(4'd6, d); chk("R7 zero bit kept", d, 32'h200);
    wrr(4'd6, 32'h00000200);
    rd(4'd6, d); chk("R7 one clears", d, 32'h0);
    chk("R7 irq low after clear", {31'b0, irq_lo}, 32'h0);
    lo_flags[39:36] = 4'b0000; settle();
    wrr(4'd6, 32'h00000200);
    rd(4'd6, d); chk("R7 set wins over clear", d, 32'h200);
    wrr(4'd4, 32'h0);
    lo_flags = '0;
    wrr(4'd1, 32'h0);
  endtask

  task automatic t_upper_r5();
    logic [31:0] d;
    wrr(4'd0, 32'h77777777);
    wrr(4'd5, 32'h00000008);
    @(negedge clk); full = 32'hFFFFFFFF; settle();
    rd(4'd7, d); chk("R5 full and source ignored", d, 32'h0);
    chk("R5 irq_hi quiet", {31'b0, irq_hi}, 32'h0);
    nne = 32'h00000008; settle();
    rd(4'd7, d); chk("R5 nne raises", d, 32'h8);
    chk("R9 irq_hi high", {31'b0, irq_hi}, 32'h1);
    chk("R9 irq_lo stays low", {31'b0, irq_lo}, 32'h0);
    wrr(4'd5, 32'h0);
    rd(4'd7, d); chk("R8 upper disable clears", d, 32'h0);
    nne = '0; full = '0;
    wrr(4'd0, 32'h0);
  endtask

  task automatic t_flags_r10();
    logic [31:0] d;
    @(negedge clk);
    lo_flags = {32'h01234567, 32'h89ABCDEF, 32'hA5A5A5A5, 32'h5A5A5A5A};
    nne = 32'hC0FFEE00; full = 32'h00BEEF11;
    @(posedge clk); @(negedge clk);
    rd(4'd8, d);  chk("R10 flag word 0", d, 32'h5A5A5A5A);
    rd(4'd9, d);  chk("R10 flag word 1", d, 32'hA5A5A5A5);
    rd(4'd11, d); chk("R10 flag word 3", d, 32'h01234567);
    rd(4'd12, d); chk("R10 nne word", d, 32'hC0FFEE00);
    rd(4'd13, d); chk("R10 full word", d, 32'h00BEEF11);
    lo_flags = '0; nne = '0; full = '0;
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wr = 1'b0; wdata = '0;
    lo_flags = '0; nne = '0; full = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_layout();
    t_select_r3();
    t_invert_r4();
    t_upper_r5();
    t_flags_r10();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule